// File: doc/BRIEF.md
# Quad DAC Register Update Controller

This block is the digital register core of a four-channel serially loaded converter. A host shifts a 24-bit frame into it on a serial clock while the active-low frame-select line is low. When frame-select returns high, the frame is decoded into an operation, a channel address and a 16-bit word. Every channel holds an input register, which is the staging value, and a DAC register, which is the value presented on the output.

The level of the active-low load pin decides how DAC registers get new values. With the pin low, a data write goes straight through to the addressed channel when the frame closes. With the pin high, the write only stages data, and a later falling edge of the pin copies all four staged values at once.

The block also provides:
- an active-low clear pin and a matching clear command, which force the outputs to zero-scale or midscale;
- per-channel power gating, where a write to a channel that is powered down is dropped;
- a coding pin that converts two's-complement words to offset binary on channels set to a bipolar range.

All pins are sampled into the system clock through two-flop synchronizers. The serial clock is oversampled in the same way.

Top module: `quad_dac_core`

## Requirements
- R1: A frame is shifted in MSB first, one bit on each falling edge of `sclk`, while `cs_n` is low. It is accepted only when exactly 24 bits arrived and its reserved bit is 0. The frame layout is:
  - bit 23: read flag;
  - bit 22: reserved;
  - bits 21:19: register select (000 data, 001 range, 010 power, 011 control);
  - bits 18:16: channel address;
  - bits 15:0: data.
  A frame with any other bit count changes nothing.
- R2: A data write accepted while `load_n` is high updates only the input register. The DAC outputs do not change.
- R3: A data write accepted while `load_n` is low updates the addressed DAC register when `cs_n` rises. The DAC outputs change only on a frame, a `load_n` fall or a clear.
- R4: A falling edge of `load_n` while `cs_n` is high copies every input register into its DAC register.
- R5: While `clr_n` is low, every DAC register holds the clear code. The clear code is 0x0000 when clear-select is 0 and 0x8000 when it is 1. Data writes made during the clear still reach the input registers but not the DAC registers. After `clr_n` is released, the cleared value remains until a new value is loaded.
- R6: After reset:
  - all outputs are 0;
  - all channels are powered down;
  - clear-select is 0;
  - all channels are unipolar.
- R7: A power frame (select 010) sets channel n powered up when data bit n is 1. Data writes to a powered-down channel change neither of its registers.
- R8: A control frame with address 001 sets clear-select from data bit 0. A control frame with address 100 performs the same clear as the pin.
- R9: In data writes, address 4 selects all channels. Addresses 5 to 7 select none.
- R10: A range frame (select 001) marks the addressed channel(s) bipolar from data bit 0. On a bipolar channel with `twos_comp` high, the stored word has its MSB inverted. Unipolar channels store the word unchanged.
- R11: Frames with the read flag set have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock; data sampled on its falling edge |
| sdin | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame select |
| load_n | input | 1 | Active-low load pin selecting the update mode |
| clr_n | input | 1 | Active-low clear |
| twos_comp | input | 1 | High: bipolar words arrive in two's complement |
| dac_out | output | 64 | DAC registers, channel n at bits 16n+15:16n |

## Verification
Each pin passes two synchronizer flops and one edge flop. A change of `cs_n`, `load_n` or `clr_n` therefore reaches `dac_out` at the third rising clock edge after it. The bench waits at least eight clock cycles after raising `cs_n` or moving `load_n` before each check. It samples `dac_out` on a falling clock edge, so every result has settled and no check races the update edge. Serial bits are held four cycles per `sclk` level, which is enough for each of them to pass the synchronizers.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

    localparam int CH_COUNT = 4;
    localparam int CODE_W   = 16;
    localparam int FRAME_W  = 24;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] ADDR_BROADCAST = 3'd4;
    localparam logic [ADDR_W-1:0] CTRL_CFG       = 3'd1;
    localparam logic [ADDR_W-1:0] CTRL_CLEAR     = 3'd4;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'b000,
        SEL_RANGE = 3'b001,
        SEL_POWER = 3'b010,
        SEL_CTRL  = 3'b011
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              rsvd;
        reg_sel_e          sel;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] data;
    } frame_t;

    // Two's complement to offset binary: flip the MSB on bipolar channels.
    function automatic logic [CODE_W-1:0] code_in(input logic [CODE_W-1:0] raw,
                                                  input logic bipolar,
                                                  input logic twos);
        code_in = raw;
        code_in[CODE_W-1] = raw[CODE_W-1] ^ (bipolar & twos);
    endfunction

    function automatic logic [CODE_W-1:0] clear_code(input logic mid);
        clear_code = '0;
        clear_code[CODE_W-1] = mid;
    endfunction

endpackage

// File: rtl/qdc_sync.sv
module qdc_sync #(
    parameter int       W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/qdc_frame_rx.sv
module qdc_frame_rx import qdc_pkg::*; #(
    parameter int FRAME_BITS = FRAME_W,
    localparam int CNT_W = $clog2(FRAME_BITS + 2)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_lvl,
    input  logic   cs_rise,
    input  logic   sclk_fall,
    input  logic   sdin_lvl,
    output logic   frame_valid,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shreg_q;
    logic [CNT_W-1:0]      cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (cs_lvl) begin
            cnt_q <= '0;
        end else if (sclk_fall) begin
            shreg_q <= {shreg_q[FRAME_BITS-2:0], sdin_lvl};
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign frame       = frame_t'(shreg_q);
    assign frame_valid = cs_rise && (cnt_q == CNT_FULL) && !frame.rsvd;
endmodule

// File: rtl/qdc_chan_bank.sv
module qdc_chan_bank import qdc_pkg::*; #(
    parameter int NCH = CH_COUNT,
    parameter int DW  = CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  frame_t            frame,
    input  logic              load_lvl,
    input  logic              load_fall,
    input  logic              cs_lvl,
    input  logic              clr_lvl,
    input  logic              tc_lvl,
    output logic [NCH*DW-1:0] dac_out
);
    logic [NCH-1:0] pwr_q;
    logic           clr_mid_q;
    logic is_wr, data_wr, range_wr, power_wr, cfg_wr, clr_cmd, clear_now, bulk_load;

    always_comb begin
        is_wr     = frame_valid && !frame.rd;
        data_wr   = is_wr && (frame.sel == SEL_DATA);
        range_wr  = is_wr && (frame.sel == SEL_RANGE);
        power_wr  = is_wr && (frame.sel == SEL_POWER);
        cfg_wr    = is_wr && (frame.sel == SEL_CTRL) && (frame.addr == CTRL_CFG);
        clr_cmd   = is_wr && (frame.sel == SEL_CTRL) && (frame.addr == CTRL_CLEAR);
        clear_now = !clr_lvl || clr_cmd;
        bulk_load = load_fall && cs_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q     <= '0;
            clr_mid_q <= 1'b0;
        end else begin
            if (power_wr) pwr_q     <= frame.data[NCH-1:0];
            if (cfg_wr)   clr_mid_q <= frame.data[0];
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic          bip_q;
        logic [DW-1:0] in_q, dac_q, wr_code;
        logic          hit, in_wr;

        assign hit     = (frame.addr == ADDR_W'(ch)) || (frame.addr == ADDR_BROADCAST);
        assign in_wr   = data_wr && hit && pwr_q[ch];
        assign wr_code = code_in(frame.data, bip_q, tc_lvl);

        always_ff @(posedge clk) begin
            if (rst) begin
                bip_q <= 1'b0;
                in_q  <= '0;
                dac_q <= '0;
            end else begin
                if (range_wr && hit) bip_q <= frame.data[0];
                if (in_wr)           in_q  <= wr_code;
                if (clear_now)                 dac_q <= clear_code(clr_mid_q);
                else if (in_wr && !load_lvl)   dac_q <= wr_code;
                else if (bulk_load)            dac_q <= in_q;
            end
        end

        assign dac_out[ch*DW +: DW] = dac_q;
    end
endmodule

// File: rtl/quad_dac_core.sv
module quad_dac_core import qdc_pkg::*; #(
    parameter int NCH = CH_COUNT,
    parameter int DW  = CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              cs_n,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic              twos_comp,
    output logic [NCH*DW-1:0] dac_out
);
    localparam int PIN_N = 6;

    logic [PIN_N-1:0] pins_lvl;
    logic sclk_lvl, cs_lvl, load_lvl, clr_lvl, sdin_lvl, tc_lvl;
    logic sclk_prev_q, cs_prev_q, load_prev_q;
    logic sclk_fall, cs_rise, load_fall;
    logic   frame_valid;
    frame_t frame;

    qdc_sync #(.W(PIN_N), .RST_VAL(6'b111100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk, cs_n, load_n, clr_n, sdin, twos_comp}),
        .q   (pins_lvl)
    );

    assign {sclk_lvl, cs_lvl, load_lvl, clr_lvl, sdin_lvl, tc_lvl} = pins_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b1;
            cs_prev_q   <= 1'b1;
            load_prev_q <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_lvl;
            cs_prev_q   <= cs_lvl;
            load_prev_q <= load_lvl;
        end
    end

    assign sclk_fall = sclk_prev_q && !sclk_lvl;
    assign cs_rise   = !cs_prev_q && cs_lvl;
    assign load_fall = load_prev_q && !load_lvl;

    qdc_frame_rx #(.FRAME_BITS(FRAME_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .cs_lvl      (cs_lvl),
        .cs_rise     (cs_rise),
        .sclk_fall   (sclk_fall),
        .sdin_lvl    (sdin_lvl),
        .frame_valid (frame_valid),
        .frame       (frame)
    );

    qdc_chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .frame       (frame),
        .load_lvl    (load_lvl),
        .load_fall   (load_fall),
        .cs_lvl      (cs_lvl),
        .clr_lvl     (clr_lvl),
        .tc_lvl      (tc_lvl),
        .dac_out     (dac_out)
    );
endmodule

// File: rtl/qdc_checker.sv
module qdc_checker import qdc_pkg::*; #(
    parameter int NCH = CH_COUNT,
    parameter int DW  = CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH*DW-1:0] dac_out,
    input logic              frame_valid,
    input frame_t            frame,
    input logic              load_lvl,
    input logic              load_fall,
    input logic              clr_lvl
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q && !rst) begin
            AST_DAC_ZERO_AFTER_RESET: assert (dac_out == '0); // R6
        end
    end

    AST_DEFERRED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !frame.rd && frame.sel == SEL_DATA && load_lvl && clr_lvl)
        |=> $stable(dac_out)); // R2

    AST_DAC_CHANGES_ONLY_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
        (!$past(frame_valid) && !$past(load_fall) && $past(clr_lvl))
        |-> $stable(dac_out)); // R3

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_CLEAR_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
            !clr_lvl |=> (dac_out[ch*DW +: DW] == '0 ||
                          dac_out[ch*DW +: DW] == {1'b1, {(DW-1){1'b0}}})); // R5
    end
endmodule

bind quad_dac_core qdc_checker #(.NCH(NCH), .DW(DW)) u_qdc_checker (
    .clk         (clk),
    .rst         (rst),
    .dac_out     (dac_out),
    .frame_valid (frame_valid),
    .frame       (frame),
    .load_lvl    (load_lvl),
    .load_fall   (load_fall),
    .clr_lvl     (clr_lvl)
);

// File: tb/quad_dac_core_bench.sv
module quad_dac_core_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, sdin = 1'b0, cs_n = 1'b1, load_n = 1'b1, clr_n = 1'b1, twos_comp = 1'b0;
    logic [63:0] dac_out;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    quad_dac_core u_quad_dac_core (
        .clk(clk), .rst(rst), .sclk(sclk), .sdin(sdin), .cs_n(cs_n),
        .load_n(load_n), .clr_n(clr_n), .twos_comp(twos_comp), .dac_out(dac_out)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [23:0] frm;
        logic        ld;
        logic        tc;
        logic [63:0] exp;
    } vec_t;

    // frame high byte = {rd, rsvd, sel[2:0], addr[2:0]}; expected = {ch3, ch2, ch1, ch0}
    localparam vec_t VEC [11] = '{
        '{"R7",  24'h10000F, 1'b0, 1'b0, 64'h0000_0000_0000_0000},
        '{"R3",  24'h001234, 1'b0, 1'b0, 64'h0000_0000_0000_1234},
        '{"R2",  24'h01ABCD, 1'b1, 1'b0, 64'h0000_0000_0000_1234},
        '{"R9",  24'h045555, 1'b0, 1'b0, 64'h5555_5555_5555_5555},
        '{"R9",  24'h057777, 1'b0, 1'b0, 64'h5555_5555_5555_5555},
        '{"R11", 24'h829999, 1'b0, 1'b0, 64'h5555_5555_5555_5555},
        '{"R10", 24'h0A0001, 1'b0, 1'b0, 64'h5555_5555_5555_5555},
        '{"R10", 24'h020123, 1'b0, 1'b1, 64'h5555_8123_5555_5555},
        '{"R10", 24'h030123, 1'b0, 1'b1, 64'h0123_8123_5555_5555},
        '{"R7",  24'h100001, 1'b0, 1'b0, 64'h0123_8123_5555_5555},
        '{"R7",  24'h012222, 1'b0, 1'b0, 64'h0123_8123_5555_5555}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] f, input int nbits);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 24) ? f[23-i] : 1'b0;
            wait_clk(4);
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic check(input string tag, input logic [63:0] exp);
        n_chk++;
        if (dac_out !== exp) begin
            n_fail++;
            $display("FAIL %s: dac_out=%h expected %h", tag, dac_out, exp);
        end
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        check("R6 reset value", 64'h0);
        send(24'h001111, 24);
        check("R6 powered down at reset", 64'h0);

        for (int v = 0; v < 11; v++) begin
            load_n    = VEC[v].ld;
            twos_comp = VEC[v].tc;
            wait_clk(4);
            send(VEC[v].frm, 24);
            check($sformatf("%s vector %0d", VEC[v].tag, v), VEC[v].exp);
        end
        twos_comp = 1'b0;
        load_n    = 1'b0;

        send(24'h10000F, 24);              // power all up again
        send(24'h009999, 23);
        check("R1 short frame", 64'h0123_8123_5555_5555);
        send(24'h009999, 25);
        check("R1 long frame", 64'h0123_8123_5555_5555);
        send(24'h409999, 24);
        check("R1 reserved bit set", 64'h0123_8123_5555_5555);

        load_n = 1'b1;
        wait_clk(8);
        send(24'h001000, 24);
        send(24'h012000, 24);
        check("R2 staged only", 64'h0123_8123_5555_5555);
        load_n = 1'b0;
        wait_clk(8);
        check("R4 simultaneous load", 64'h0123_8123_2000_1000);
        load_n = 1'b1;
        wait_clk(8);

        send(24'h190001, 24);              // clear-select midscale
        clr_n = 1'b0;
        wait_clk(8);
        check("R5 clear to midscale", 64'h8000_8000_8000_8000);
        load_n = 1'b0;
        wait_clk(8);
        check("R5 load blocked during clear", 64'h8000_8000_8000_8000);
        load_n = 1'b1;
        wait_clk(8);
        send(24'h004444, 24);
        clr_n = 1'b1;
        wait_clk(8);
        check("R5 held after release", 64'h8000_8000_8000_8000);
        load_n = 1'b0;
        wait_clk(8);
        check("R5 staged write survives clear", 64'h0123_8123_2000_4444);

        send(24'h190000, 24);              // clear-select zero
        send(24'h1C0000, 24);              // clear command
        check("R8 clear command zero-scale", 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule